// File: doc/BRIEF.md
# Bus-Mapped Quad SPI NOR Flash Controller

This block is a Wishbone slave that gives a processor access to a serial NOR flash through two select lines. The data window maps flash contents. A bus read there becomes a fast quad-output read that returns one 32-bit word. A bus write there becomes a write-enable followed by a quad page-program of that word. The control window is a small register file of eight slots. It holds a command/status slot, a slot that maps onto the flash's volatile configuration byte, a slot that reads the device identification word, and five empty slots.

The controller drives chip select, a mode-0 serial clock at half the system clock, and four data lines, each with its own output enable. Opcodes and addresses go out serially on line 0. Single-bit replies come back on line 1. Read data and program data use all four lines, most significant nibble first.

After a program, the controller remembers that the flash is busy. Before it performs the next data-window access, it polls the flash status until the write-in-progress bit clears. The number of dummy clocks on the read path follows the upper nibble of the last accepted configuration write.

Top module: `qspiFlashCtrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `wbAck` is low and `wbStall` is low.
- R2: A data-window read sends opcode 0x6B serially, then the 24-bit byte address (`wbAddr` followed by two zero bits) serially, then the dummy clocks, then 8 quad clocks. The first nibble received lands in bits 31:28 of `wbDataOut`.
- R3: The dummy clock count of R2 equals bits 7:4 of the configuration byte. It is 15 after reset and 8 after 0x85 has been accepted, and read data is aligned for both values.
- R4: A data-window write issues two commands: opcode 0x06, then a separate opcode 0x32 with the address followed by the 32-bit word on 4 lines (8 clocks). Reading that address back returns the word.
- R5: Control slot 0 (`wbAddr[2:0]`=0) reads as {24'b0, flash status byte}, with write-in-progress in bit 0. After a program, the next data-window access first repeats opcode 0x05 until bit 0 reads clear, and only then issues its own command.
- R6: Writing a value with bit 30 set to slot 0 issues opcode 0x06. Writing a value with bit 30 clear causes no flash traffic. A configuration write made without a preceding write-enable leaves the configuration byte and the dummy count unchanged.
- R7: Slot 1 maps to the configuration byte. A write sends opcode 0x81 and the low data byte; a read sends opcode 0x85 and returns the byte in bits 7:0, exactly as written.
- R8: A read of slot 2 sends opcode 0x9F and returns the 32 serially received bits, first bit in bit 31. For the target device this is 32'h20BA1810.
- R9: Slots 3 to 7 read as zero, ignore writes, start no flash command, and acknowledge on the cycle after acceptance.
- R10: A request is accepted while `wbStall` is low. `wbStall` then stays high until the acknowledge, `wbAck` is high for exactly one cycle, and chip select is low only while `wbStall` is high.
- R11: Between commands, chip select stays high for at least two clock cycles (one serial clock period), and the serial clock is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wbCyc | input | 1 | Bus cycle valid |
| wbStbData | input | 1 | Strobe for the data window |
| wbStbCtrl | input | 1 | Strobe for the control window |
| wbWe | input | 1 | Write when high |
| wbAddr | input | ADDR_W-2 | Word address; bits 2:0 select the control slot |
| wbDataIn | input | 32 | Write data |
| wbStall | output | 1 | Controller busy, request not accepted |
| wbAck | output | 1 | One-cycle completion pulse |
| wbDataOut | output | 32 | Read data, valid with `wbAck` |
| flashCsN | output | 1 | Active-low chip select |
| flashSck | output | 1 | Serial clock, idles low |
| flashDatOut | output | 4 | Values driven on data lines 3:0 |
| flashDatOe | output | 4 | Output enables for data lines 3:0 |
| flashDatIn | input | 4 | Values sampled from data lines 3:0 |

## Verification
If the dummy count or the sampling point is off by one clock, every quad read word is shifted by one nibble. This appears on `wbDataOut` at the first read after reset, and again at the first read after the configuration changes. If the busy tracking is wrong, the controller skips or over-extends the status polling. The bench sees this in the number of chip-select pulses during the access that follows a program, and a stale word may come back. Handshake state errors show up on the same cycle: a second acknowledge, a drop in stall, or chip select low while the bus is idle.

// File: rtl/qspiPkg.sv
package qspiPkg;

  typedef enum logic [2:0] {
    OP_READ, OP_PROG, OP_WREN, OP_STAT, OP_CFGRD, OP_CFGWR, OP_ID
  } flashOp_t;

  // One shift segment requested by the sequencer from the shifter
  typedef struct packed {
    logic        start;
    logic        quad;
    logic        drive;
    logic [5:0]  nClk;
    logic [31:0] word;
  } segReq_t;

  localparam logic [7:0] OPC_QREAD  = 8'h6B;
  localparam logic [7:0] OPC_QPROG  = 8'h32;
  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_STATUS = 8'h05;
  localparam logic [7:0] OPC_CFGRD  = 8'h85;
  localparam logic [7:0] OPC_CFGWR  = 8'h81;
  localparam logic [7:0] OPC_IDENT  = 8'h9F;

  function automatic logic [7:0] opcodeOf(flashOp_t o);
    case (o)
      OP_READ:  return OPC_QREAD;
      OP_PROG:  return OPC_QPROG;
      OP_WREN:  return OPC_WREN;
      OP_STAT:  return OPC_STATUS;
      OP_CFGRD: return OPC_CFGRD;
      OP_CFGWR: return OPC_CFGWR;
      default:  return OPC_IDENT;
    endcase
  endfunction

  // Index of the final segment of each command
  function automatic logic [1:0] lastSeg(flashOp_t o);
    case (o)
      OP_READ: return 2'd3;
      OP_PROG: return 2'd2;
      OP_WREN: return 2'd0;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/qspiShifter.sv
module qspiShifter
  import qspiPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  segReq_t     seg,
  input  logic [3:0]  din,
  output logic        busy,
  output logic [31:0] rx,
  output logic        sck,
  output logic [3:0]  dqOut,
  output logic [3:0]  dqOe
);

  logic [31:0] shOut;
  logic [5:0]  cnt;
  logic        quadR;
  logic        driveR;

  // Each serial clock lasts two system clocks: low phase, then high phase.
  // Input is captured at the end of the high phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sck    <= 1'b0;
      shOut  <= '0;
      rx     <= '0;
      cnt    <= '0;
      quadR  <= 1'b0;
      driveR <= 1'b1;
    end else if (seg.start) begin
      busy   <= (seg.nClk != 6'd0);
      sck    <= 1'b0;
      shOut  <= seg.word;
      cnt    <= seg.nClk;
      quadR  <= seg.quad;
      driveR <= seg.drive;
    end else if (busy) begin
      if (!sck) begin
        sck <= 1'b1;
      end else begin
        sck <= 1'b0;
        if (quadR) begin
          rx    <= {rx[27:0], din};
          shOut <= {shOut[27:0], 4'h0};
        end else begin
          rx    <= {rx[30:0], din[1]};
          shOut <= {shOut[30:0], 1'b0};
        end
        cnt <= cnt - 6'd1;
        if (cnt == 6'd1) busy <= 1'b0;
      end
    end
  end

  // Serial mode keeps lines 2 and 3 driven high; line 1 is the input
  always_comb begin
    if (quadR) begin
      dqOut = shOut[31:28];
      dqOe  = driveR ? 4'hF : 4'h0;
    end else begin
      dqOut = {2'b11, 1'b0, shOut[31]};
      dqOe  = 4'b1101;
    end
  end

endmodule

// File: rtl/qspiSequencer.sv
module qspiSequencer
  import qspiPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SLOT_W      = 3,
  parameter int GAP_CLKS    = 2,
  parameter logic [3:0] DUMMY_RESET = 4'd15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbCyc,
  input  logic              wbStbData,
  input  logic              wbStbCtrl,
  input  logic              wbWe,
  input  logic [ADDR_W-3:0] wbAddr,
  input  logic [31:0]       wbDataIn,
  output logic              wbStall,
  output logic              wbAck,
  output logic [31:0]       wbDataOut,
  input  logic              busy,
  input  logic [31:0]       rx,
  output segReq_t           seg,
  output logic              csN
);

  localparam logic [5:0] ADDR_CLKS = 6'(ADDR_W);
  localparam int GAP_W = $clog2(GAP_CLKS) + 1;
  localparam logic [SLOT_W-1:0] SLOT_CMD = SLOT_W'(0);
  localparam logic [SLOT_W-1:0] SLOT_CFG = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] SLOT_ID  = SLOT_W'(2);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP, S_ACK} state_t;

  state_t             state;
  flashOp_t           op, pendOp, reqOp;
  logic               reqRun;
  logic [1:0]         step;
  logic               launched, more, polling, chainProg;
  logic               wipPending, welTrack;
  logic [3:0]         dummyCfg;
  logic [GAP_W-1:0]   gapCnt;
  logic [ADDR_W-1:0]  addrR;
  logic [31:0]        dataR, rdWord;

  // Decode of an incoming request
  always_comb begin
    reqOp  = OP_READ;
    reqRun = 1'b0;
    if (wbStbData) begin
      reqOp  = wbWe ? OP_WREN : OP_READ;
      reqRun = 1'b1;
    end else begin
      case (wbAddr[SLOT_W-1:0])
        SLOT_CMD: begin
          reqOp  = wbWe ? OP_WREN : OP_STAT;
          reqRun = wbWe ? wbDataIn[30] : 1'b1;
        end
        SLOT_CFG: begin
          reqOp  = wbWe ? OP_CFGWR : OP_CFGRD;
          reqRun = 1'b1;
        end
        SLOT_ID: begin
          reqOp  = OP_ID;
          reqRun = !wbWe;
        end
        default: ;
      endcase
    end
  end

  // Segment for the current step of the current command
  always_comb begin
    seg       = '0;
    seg.start = (state == S_RUN) && !launched;
    seg.drive = 1'b1;
    seg.nClk  = 6'd8;
    seg.word  = {opcodeOf(op), 24'h0};
    case (step)
      2'd1: begin
        seg.word = '0;
        case (op)
          OP_READ, OP_PROG: begin
            seg.nClk = ADDR_CLKS;
            seg.word = {addrR, {(32-ADDR_W){1'b0}}};
          end
          OP_CFGWR: seg.word = {dataR[7:0], 24'h0};
          OP_ID:    seg.nClk = 6'd32;
          default:  ;
        endcase
      end
      2'd2: begin
        seg.quad = 1'b1;
        if (op == OP_PROG) begin
          seg.word = dataR;
        end else begin
          seg.drive = 1'b0;
          seg.nClk  = {2'b00, dummyCfg};
          seg.word  = '0;
        end
      end
      2'd3: begin
        seg.quad  = 1'b1;
        seg.drive = 1'b0;
        seg.word  = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      op         <= OP_READ;
      pendOp     <= OP_READ;
      step       <= '0;
      launched   <= 1'b0;
      more       <= 1'b0;
      polling    <= 1'b0;
      chainProg  <= 1'b0;
      wipPending <= 1'b0;
      welTrack   <= 1'b0;
      dummyCfg   <= DUMMY_RESET;
      gapCnt     <= '0;
      addrR      <= '0;
      dataR      <= '0;
      rdWord     <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (wbCyc && (wbStbData || wbStbCtrl)) begin
            addrR     <= {wbAddr, 2'b00};
            dataR     <= wbDataIn;
            rdWord    <= '0;
            step      <= '0;
            launched  <= 1'b0;
            chainProg <= wbStbData && wbWe;
            if (!reqRun) begin
              state <= S_ACK;
            end else begin
              state <= S_RUN;
              if (wbStbData && wipPending) begin
                op      <= OP_STAT;
                polling <= 1'b1;
                pendOp  <= reqOp;
              end else begin
                op <= reqOp;
              end
            end
          end
        end
        S_RUN: begin
          if (!launched) begin
            launched <= 1'b1;
          end else if (!busy) begin
            launched <= 1'b0;
            if (step != lastSeg(op)) begin
              step <= step + 2'd1;
            end else begin
              step   <= '0;
              state  <= S_GAP;
              gapCnt <= '0;
              more   <= 1'b0;
              case (op)
                OP_STAT: begin
                  if (!rx[0]) wipPending <= 1'b0;
                  if (polling) begin
                    more <= 1'b1;
                    if (!rx[0]) begin
                      polling <= 1'b0;
                      op      <= pendOp;
                    end
                  end else begin
                    rdWord <= {24'h0, rx[7:0]};
                  end
                end
                OP_WREN: begin
                  welTrack <= 1'b1;
                  if (chainProg) begin
                    chainProg <= 1'b0;
                    op        <= OP_PROG;
                    more      <= 1'b1;
                  end
                end
                OP_PROG: begin
                  welTrack   <= 1'b0;
                  wipPending <= 1'b1;
                end
                OP_CFGWR: begin
                  if (welTrack) dummyCfg <= dataR[7:4];
                  welTrack <= 1'b0;
                end
                OP_CFGRD: rdWord <= {24'h0, rx[7:0]};
                default:  rdWord <= rx;
              endcase
            end
          end
        end
        S_GAP: begin
          gapCnt <= gapCnt + GAP_W'(1);
          if (gapCnt == GAP_W'(GAP_CLKS - 1)) state <= more ? S_RUN : S_ACK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign csN       = (state != S_RUN);
  assign wbStall   = (state != S_IDLE);
  assign wbAck     = (state == S_ACK);
  assign wbDataOut = rdWord;

endmodule

// File: rtl/qspiFlashCtrl.sv
module qspiFlashCtrl
  import qspiPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int CTRL_SLOTS  = 8,
  parameter int GAP_CLKS    = 2,
  parameter logic [3:0] DUMMY_RESET = 4'd15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbCyc,
  input  logic              wbStbData,
  input  logic              wbStbCtrl,
  input  logic              wbWe,
  input  logic [ADDR_W-3:0] wbAddr,
  input  logic [31:0]       wbDataIn,
  output logic              wbStall,
  output logic              wbAck,
  output logic [31:0]       wbDataOut,
  output logic              flashCsN,
  output logic              flashSck,
  output logic [3:0]        flashDatOut,
  output logic [3:0]        flashDatOe,
  input  logic [3:0]        flashDatIn
);

  localparam int SLOT_W = $clog2(CTRL_SLOTS);

  segReq_t     seg;
  logic        busy;
  logic [31:0] rx;

  qspiSequencer #(
    .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .GAP_CLKS(GAP_CLKS), .DUMMY_RESET(DUMMY_RESET)
  ) u_seq (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStbData(wbStbData),
    .wbStbCtrl(wbStbCtrl), .wbWe(wbWe), .wbAddr(wbAddr), .wbDataIn(wbDataIn),
    .wbStall(wbStall), .wbAck(wbAck), .wbDataOut(wbDataOut),
    .busy(busy), .rx(rx), .seg(seg), .csN(flashCsN)
  );

  qspiShifter u_shift (
    .clk(clk), .rstN(rstN), .seg(seg), .din(flashDatIn), .busy(busy),
    .rx(rx), .sck(flashSck), .dqOut(flashDatOut), .dqOe(flashDatOe)
  );

endmodule

// File: rtl/qspiFlashCtrl_checker.sv
module qspiFlashCtrl_checker (
  input logic clk,
  input logic rstN,
  input logic wbAck,
  input logic wbStall,
  input logic flashCsN,
  input logic flashSck
);

  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |=> !wbAck);

  a_r10_ack_stalled: assert property (@(posedge clk) disable iff (!rstN)
    wbAck |-> wbStall);

  a_r10_cs_in_xfer: assert property (@(posedge clk) disable iff (!rstN)
    !flashCsN |-> wbStall);

  a_r11_sck_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    flashCsN |-> !flashSck);

  a_r11_cs_gap: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flashCsN) |=> flashCsN);

endmodule

bind qspiFlashCtrl qspiFlashCtrl_checker u_chk (.*);

// File: tb/qspiFlashCtrl_tb.sv
`timescale 1ns/1ps
module qspiFlashCtrl_tb;

  localparam logic [31:0] DEV_ID = 32'h20BA1810;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wbCyc = 1'b0, wbStbData = 1'b0, wbStbCtrl = 1'b0, wbWe = 1'b0;
  logic [21:0] wbAddr = '0;
  logic [31:0] wbDataIn = '0;
  logic        wbStall, wbAck;
  logic [31:0] wbDataOut;
  logic        flashCsN, flashSck;
  logic [3:0]  flashDatOut, flashDatOe;
  logic [3:0]  mOut = 4'h0;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  qspiFlashCtrl u_dut (
    .clk(clk), .rstN(rstN), .wbCyc(wbCyc), .wbStbData(wbStbData),
    .wbStbCtrl(wbStbCtrl), .wbWe(wbWe), .wbAddr(wbAddr), .wbDataIn(wbDataIn),
    .wbStall(wbStall), .wbAck(wbAck), .wbDataOut(wbDataOut),
    .flashCsN(flashCsN), .flashSck(flashSck), .flashDatOut(flashDatOut),
    .flashDatOe(flashDatOe), .flashDatIn(mOut)
  );

  // ---------------- behavioural flash responder ----------------
  logic [7:0]  mCmd = '0;
  logic [23:0] mAddr = '0;
  logic [31:0] mIn = '0;
  int          mCnt = 0;
  logic        mWel = 1'b0;
  int          mWipLeft = 0;
  logic [7:0]  mVcr = 8'hFB;
  logic [31:0] mMem [16];

  function automatic logic [31:0] patt(int i);
    return 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
  endfunction

  initial for (int i = 0; i < 16; i++) mMem[i] = patt(i);

  always @(negedge flashCsN) begin
    mCnt = 0; mCmd = '0; mAddr = '0; mIn = '0;
  end

  always @(posedge flashSck) if (!flashCsN) begin
    if (mCnt < 8) mCmd = {mCmd[6:0], flashDatOut[0]};
    else if ((mCmd == 8'h6B || mCmd == 8'h32) && mCnt < 32) mAddr = {mAddr[22:0], flashDatOut[0]};
    else if (mCmd == 8'h32 && mCnt < 40) mIn = {mIn[27:0], flashDatOut};
    else if (mCmd == 8'h81 && mCnt < 16) mIn = {mIn[30:0], flashDatOut[0]};
    mCnt++;
  end

  always @(negedge flashSck) if (!flashCsN) begin
    int c;
    int d;
    logic [7:0] st;
    c = mCnt;
    d = int'(mVcr[7:4]);
    st = {6'b0, mWel, (mWipLeft > 0)};
    mOut = 4'h0;
    case (mCmd)
      8'h6B: if (c >= 32 + d && c < 40 + d)
               mOut = 4'(mMem[mAddr[5:2]] >> (28 - 4 * (c - 32 - d)));
      8'h05: if (c >= 8 && c < 16) mOut[1] = st[15 - c];
      8'h85: if (c >= 8 && c < 16) mOut[1] = mVcr[15 - c];
      8'h9F: if (c >= 8 && c < 40) mOut[1] = DEV_ID[39 - c];
      default: ;
    endcase
  end

  always @(posedge flashCsN) begin
    case (mCmd)
      8'h06: if (mCnt == 8) mWel = 1'b1;
      8'h32: if (mCnt == 40 && mWel) begin mMem[mAddr[5:2]] = mIn; mWel = 1'b0; mWipLeft = 3; end
      8'h81: if (mCnt == 16) begin if (mWel) mVcr = mIn[7:0]; mWel = 1'b0; end
      8'h05: if (mCnt == 16 && mWipLeft > 0) mWipLeft--;
      default: ;
    endcase
  end

  // ---------------- pin monitor ----------------
  logic prevCs = 1'b1;
  int csFalls = 0, highRun = 0, gapViol = 0, sckViol = 0;
  always @(negedge clk) if (rstN) begin
    if (prevCs && !flashCsN) begin
      csFalls++;
      if (csFalls > 1 && highRun < 2) gapViol++;
    end
    if (flashCsN) highRun++; else highRun = 0;
    if (flashCsN && flashSck) sckViol++;
    prevCs = flashCsN;
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wbXfer(input bit ctrl, input bit we, input logic [21:0] adr,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int ackCnt, output int lat, output int stallBad);
    @(negedge clk);
    wbCyc = 1'b1; wbStbData = !ctrl; wbStbCtrl = ctrl; wbWe = we;
    wbAddr = adr; wbDataIn = wd;
    @(negedge clk);
    wbStbData = 1'b0; wbStbCtrl = 1'b0;
    lat = 1; ackCnt = 0; rd = '0; stallBad = 0;
    for (int i = 0; i < 20000; i++) begin
      if (wbAck) begin ackCnt++; rd = wbDataOut; end
      else if (ackCnt > 0) break;
      else if (!wbStall) stallBad++;
      if (ackCnt == 0) lat++;
      @(negedge clk);
    end
    wbCyc = 1'b0;
  endtask

  task automatic rdData(input logic [21:0] a, output logic [31:0] v);
    int k, l, s;
    wbXfer(1'b0, 1'b0, a, '0, v, k, l, s);
  endtask

  task automatic ctrlRd(input logic [21:0] a, output logic [31:0] v);
    int k, l, s;
    wbXfer(1'b1, 1'b0, a, '0, v, k, l, s);
  endtask

  task automatic ctrlWr(input logic [21:0] a, input logic [31:0] d);
    logic [31:0] v;
    int k, l, s;
    wbXfer(1'b1, 1'b1, a, d, v, k, l, s);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    @(negedge clk);
    chk("R1 csN", 32'(flashCsN), 32'd1);
    chk("R1 sck", 32'(flashSck), 32'd0);
    chk("R1 ack", 32'(wbAck), 32'd0);
    chk("R1 stall", 32'(wbStall), 32'd0);
  endtask

  task automatic testIdent();
    logic [31:0] v;
    ctrlRd(22'd2, v);
    chk("R8 ident", v, DEV_ID);
  endtask

  task automatic testReadDefault();
    logic [31:0] v;
    rdData(22'd0, v);  chk("R2 R3 read15 a0", v, patt(0));
    rdData(22'd9, v);  chk("R2 R3 read15 a9", v, patt(9));
  endtask

  task automatic testCfgNoWel();
    logic [31:0] v;
    int f0;
    f0 = csFalls;
    ctrlWr(22'd0, 32'h0000_0000);
    chk("R6 no-bit30 traffic", 32'(csFalls - f0), 32'd0);
    ctrlWr(22'd1, 32'h0000_0085);
    ctrlRd(22'd1, v);
    chk("R6 cfg kept", v, 32'h0000_00FB);
    rdData(22'd4, v);
    chk("R6 R3 dummy kept", v, patt(4));
  endtask

  task automatic testCfgWrite();
    logic [31:0] v;
    ctrlWr(22'd0, 32'h4000_0000);
    ctrlWr(22'd1, 32'h0000_0085);
    ctrlRd(22'd1, v);
    chk("R7 cfg readback", v, 32'h0000_0085);
    rdData(22'd7, v);  chk("R3 read8 a7", v, patt(7));
    rdData(22'd15, v); chk("R3 read8 a15", v, patt(15));
  endtask

  task automatic testUnused();
    logic [31:0] v;
    int k, l, s, f0;
    f0 = csFalls;
    wbXfer(1'b1, 1'b1, 22'd5, 32'hFFFF_FFFF, v, k, l, s);
    wbXfer(1'b1, 1'b0, 22'd5, '0, v, k, l, s);
    chk("R9 slot5 zero", v, 32'd0);
    chk("R9 slot5 latency", 32'(l), 32'd1);
    wbXfer(1'b1, 1'b0, 22'd7, '0, v, k, l, s);
    chk("R9 slot7 zero", v, 32'd0);
    chk("R9 no traffic", 32'(csFalls - f0), 32'd0);
  endtask

  task automatic testProgram();
    logic [31:0] v;
    int k, l, s, f0;
    f0 = csFalls;
    wbXfer(1'b0, 1'b1, 22'd3, 32'hCAFE_F00D, v, k, l, s);
    chk("R4 prog commands", 32'(csFalls - f0), 32'd2);
    ctrlRd(22'd0, v);
    chk("R5 status wip", v, 32'h0000_0001);
    f0 = csFalls;
    rdData(22'd3, v);
    chk("R4 prog readback", v, 32'hCAFE_F00D);
    chk("R5 poll count", 32'(csFalls - f0), 32'd4);
    ctrlRd(22'd0, v);
    chk("R5 status idle", v, 32'h0000_0000);
  endtask

  task automatic testHandshake();
    logic [31:0] v;
    int k, l, s;
    wbXfer(1'b0, 1'b0, 22'd1, '0, v, k, l, s);
    chk("R10 ack once", 32'(k), 32'd1);
    chk("R10 stall held", 32'(s), 32'd0);
    chk("R10 read data", v, patt(1));
    chk("R11 cs gap", 32'(gapViol), 32'd0);
    chk("R11 sck idle", 32'(sckViol), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testIdent();
    testReadDefault();
    testCfgNoWel();
    testCfgWrite();
    testUnused();
    testProgram();
    testHandshake();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule